// File: doc/BRIEF.md
# Two-Step Ramped Program Sequencer

This block drives the programming of one multilevel memory cell. One start pulse runs a fixed sequence: read the cell threshold, run a first gate ramp to a point halfway to the target, read the threshold again, then run a second ramp that finishes at the target. There is never a third step. The threshold readings come through a request/acknowledge handshake that returns a signed code in DAC LSB units. The ramp is a control-gate DAC code that rises by one LSB for each slope interval.

The first ramp uses a shared overdrive for every cell. Its start code puts the gate one overdrive above the measured threshold, so injection begins close to equilibrium. The second ramp's overdrive is recomputed from the midpoint reading. A cell that lagged gets more overdrive and a cell that ran ahead gets less. All ramp arithmetic is checked against the DAC range. A result outside the range ends the sequence with an error, so a code never wraps.

Top module: `rps_two_step_prog`

## Requirements
- R1: A start pulse while idle latches the target code, overdrive and slope divider, raises busy, and raises meas_req on the next cycle. A start pulse while busy has no effect on the ongoing sequence.
- R2: meas_req stays high until the cycle in which meas_ack is sampled high, and it is low on the following cycle. meas_vt is taken in that acknowledge cycle.
- R3: If no acknowledge arrives within TMO_CYC cycles of a raised request, the request drops and the sequence ends with err and err_cause = 2'b01.
- R4: The target code is the DAC_W-bit field of lvl_table at bit offset level*DAC_W. With first reading v0, the midpoint is m = v0 + floor((T - v0)/2). The first ramp runs from max(0, v0 + ovd) up to m + ovd.
- R5: While ramp_en is high, each code is held for exactly ramp_div+1 cycles, and the next code is one higher. The final code is held for the same time, and then ramp_en drops.
- R6: After the first ramp a second reading v1 is taken. The second overdrive is ovd + m - v1. The second ramp runs from max(0, m + ovd) up to T + ovd + m - v1.
- R7: After the second ramp completes, done pulses for one cycle with err_cause = 2'b00, and busy is low on the next cycle. Exactly two ramps occur per start.
- R8: If T - v0 < 2, the sequence ends with err_cause = 2'b11 and no ramp. If v1 >= T, the sequence ends with err_cause = 2'b11 after the first ramp.
- R9: If a ramp end code would be negative or above 2^DAC_W - 1, the sequence ends with err_cause = 2'b10 and that ramp never starts. An end code exactly at full scale is accepted.
- R10: Outside a ramp, dac_code is 0 and ramp_en is low. meas_req and ramp_en are never high together. done and err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for one cell |
| level | input | LVL_BITS | Target level index |
| lvl_table | input | (2^LVL_BITS)*DAC_W | Level-to-DAC-code table, entry k at bits k*DAC_W |
| ramp_div | input | DIV_W | Slope divider: cycles per code minus one |
| ovd_base | input | DAC_W | Common overdrive of the first ramp |
| meas_req | output | 1 | Threshold reading request |
| meas_ack | input | 1 | Reading valid |
| meas_vt | input | DAC_W+2 | Signed threshold code |
| dac_code | output | DAC_W | Control-gate DAC code |
| ramp_en | output | 1 | High while a ramp runs |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_cause | output | 2 | 00 none, 01 timeout, 10 range, 11 order |

## Verification
The bench builds the block with LVL_BITS=3 and DIV_W=4, which gives an eight-entry table spaced 24 codes apart. It uses TMO_CYC=40, so the timeout path can be reached in a short run. The 8-bit DAC keeps ramps at a few hundred cycles. This lets the bench hit several cases: full scale exactly, one code past full scale, a clamped negative start, and a target only two codes above the first reading. A slope divider of zero can be mixed with larger dividers in the same run.

// File: rtl/rps_pkg.sv
package rps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MEAS0, ST_RAMP1, ST_MEAS1, ST_RAMP2, ST_DONE, ST_ERR
  } rps_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_TMO   = 2'b01,
    CAUSE_RANGE = 2'b10,
    CAUSE_ORDER = 2'b11
  } rps_cause_e;

endpackage

// File: rtl/rps_meas_port.sv
module rps_meas_port #(
  parameter int TMO_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic meas_ack,
  output logic meas_req,
  output logic got,
  output logic tmo
);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [TW-1:0] wait_cnt;

  assign got = meas_req && meas_ack;
  assign tmo = meas_req && !meas_ack && (wait_cnt == TW'(TMO_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_req <= 1'b0;
      wait_cnt <= '0;
    end else if (launch) begin
      meas_req <= 1'b1;
      wait_cnt <= '0;
    end else if (meas_req) begin
      if (got || tmo) meas_req <= 1'b0;
      else            wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rps_ramp_gen.sv
module rps_ramp_gen #(
  parameter int DAC_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DAC_W-1:0] start_code,
  input  logic [DAC_W-1:0] stop_code,
  input  logic [DIV_W-1:0] div,
  output logic [DAC_W-1:0] dac_code,
  output logic             ramp_en,
  output logic             fin
);
  logic [DAC_W-1:0] stop_q;
  logic [DIV_W-1:0] tick_cnt;
  logic             tick;

  assign tick = ramp_en && (tick_cnt == div);
  assign fin  = tick && (dac_code == stop_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_code <= '0;
      stop_q   <= '0;
      tick_cnt <= '0;
      ramp_en  <= 1'b0;
    end else if (load) begin
      dac_code <= start_code;
      stop_q   <= stop_code;
      tick_cnt <= '0;
      ramp_en  <= 1'b1;
    end else if (ramp_en) begin
      if (tick) begin
        tick_cnt <= '0;
        if (dac_code == stop_q) begin
          ramp_en  <= 1'b0;
          dac_code <= '0;
        end else begin
          dac_code <= dac_code + 1'b1;
        end
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rps_plan.sv
module rps_plan #(
  parameter int DAC_W = 8,
  parameter int CW    = DAC_W + 4
) (
  input  logic                    second,
  input  logic signed [DAC_W+1:0] vt,
  input  logic [DAC_W-1:0]        tgt,
  input  logic [DAC_W-1:0]        ovd,
  input  logic signed [CW-1:0]    mid_in,
  output logic signed [CW-1:0]    mid_out,
  output logic [DAC_W-1:0]        start_code,
  output logic [DAC_W-1:0]        stop_code,
  output logic                    order_bad,
  output logic                    range_bad
);
  localparam int TH_W = DAC_W + 2;
  localparam logic signed [CW-1:0] FULL_S = CW'((1 << DAC_W) - 1);
  localparam logic signed [CW-1:0] TWO_S  = CW'(2);

  function automatic logic signed [CW-1:0] ext_u(input logic [DAC_W-1:0] u);
    return $signed({{(CW-DAC_W){1'b0}}, u});
  endfunction

  function automatic logic signed [CW-1:0] ext_s(input logic signed [TH_W-1:0] s);
    return $signed({{(CW-TH_W){s[TH_W-1]}}, s});
  endfunction

  function automatic logic [DAC_W-1:0] sat_code(input logic signed [CW-1:0] v);
    if (v[CW-1])       return '0;
    else if (v > FULL_S) return '1;
    else               return v[DAC_W-1:0];
  endfunction

  logic signed [CW-1:0] vt_s, tgt_s, ovd_s, ovd_eff, ramp_lo, ramp_hi;

  always_comb begin
    vt_s  = ext_s(vt);
    tgt_s = ext_u(tgt);
    ovd_s = ext_u(ovd);
    if (!second) begin
      mid_out   = vt_s + ((tgt_s - vt_s) >>> 1);
      ovd_eff   = ovd_s;
      order_bad = (tgt_s - vt_s) < TWO_S;
      ramp_hi   = mid_out + ovd_eff;
    end else begin
      mid_out   = mid_in;
      ovd_eff   = ovd_s + mid_in - vt_s;
      order_bad = vt_s >= tgt_s;
      ramp_hi   = tgt_s + ovd_eff;
    end
    ramp_lo    = vt_s + ovd_eff;
    range_bad  = ramp_hi[CW-1] || (ramp_hi > FULL_S);
    start_code = sat_code(ramp_lo);
    stop_code  = sat_code(ramp_hi);
  end
endmodule

// File: rtl/rps_two_step_prog.sv
module rps_two_step_prog #(
  parameter int LVL_BITS = 2,
  parameter int DAC_W    = 8,
  parameter int DIV_W    = 8,
  parameter int TMO_CYC  = 256
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start,
  input  logic [LVL_BITS-1:0]               level,
  input  logic [(1<<LVL_BITS)*DAC_W-1:0]    lvl_table,
  input  logic [DIV_W-1:0]                  ramp_div,
  input  logic [DAC_W-1:0]                  ovd_base,
  output logic                              meas_req,
  input  logic                              meas_ack,
  input  logic signed [DAC_W+1:0]           meas_vt,
  output logic [DAC_W-1:0]                  dac_code,
  output logic                              ramp_en,
  output logic                              busy,
  output logic                              done,
  output logic                              err,
  output logic [1:0]                        err_cause
);
  import rps_pkg::*;

  localparam int MID_W = DAC_W + 4;

  rps_state_e           state;
  rps_cause_e           cause_q;
  logic [DAC_W-1:0]     tgt_q, ovd_q;
  logic [DIV_W-1:0]     div_q;
  logic signed [MID_W-1:0] mid_q, mid_new;

  logic meas_got, meas_tmo, launch, ramp_load, ramp_fin;
  logic [DAC_W-1:0] plan_start, plan_stop;
  logic plan_order_bad, plan_range_bad, in_meas, second_step;

  assign in_meas     = (state == ST_MEAS0) || (state == ST_MEAS1);
  assign second_step = (state == ST_MEAS1);
  assign launch      = ((state == ST_IDLE) && start) || ((state == ST_RAMP1) && ramp_fin);
  assign ramp_load   = in_meas && meas_got && !plan_order_bad && !plan_range_bad;

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_DONE);
  assign err       = (state == ST_ERR);
  assign err_cause = cause_q;

  rps_meas_port #(.TMO_CYC(TMO_CYC)) u_meas (
    .clk(clk), .rst_n(rst_n), .launch(launch), .meas_ack(meas_ack),
    .meas_req(meas_req), .got(meas_got), .tmo(meas_tmo)
  );

  rps_plan #(.DAC_W(DAC_W), .CW(MID_W)) u_plan (
    .second(second_step), .vt(meas_vt), .tgt(tgt_q), .ovd(ovd_q),
    .mid_in(mid_q), .mid_out(mid_new), .start_code(plan_start),
    .stop_code(plan_stop), .order_bad(plan_order_bad), .range_bad(plan_range_bad)
  );

  rps_ramp_gen #(.DAC_W(DAC_W), .DIV_W(DIV_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .load(ramp_load), .start_code(plan_start),
    .stop_code(plan_stop), .div(div_q), .dac_code(dac_code),
    .ramp_en(ramp_en), .fin(ramp_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      tgt_q   <= '0;
      ovd_q   <= '0;
      div_q   <= '0;
      mid_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          tgt_q   <= lvl_table[level*DAC_W +: DAC_W];
          ovd_q   <= ovd_base;
          div_q   <= ramp_div;
          cause_q <= CAUSE_NONE;
          state   <= ST_MEAS0;
        end
        ST_MEAS0, ST_MEAS1: begin
          if (meas_tmo) begin
            cause_q <= CAUSE_TMO;
            state   <= ST_ERR;
          end else if (meas_got) begin
            if (plan_order_bad) begin
              cause_q <= CAUSE_ORDER;
              state   <= ST_ERR;
            end else if (plan_range_bad) begin
              cause_q <= CAUSE_RANGE;
              state   <= ST_ERR;
            end else begin
              mid_q <= mid_new;
              state <= second_step ? ST_RAMP2 : ST_RAMP1;
            end
          end
        end
        ST_RAMP1: if (ramp_fin) state <= ST_MEAS1;
        ST_RAMP2: if (ramp_fin) state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rps_two_step_chk.sv
module rps_two_step_chk #(
  parameter int DAC_W   = 8,
  parameter int DIV_W   = 8,
  parameter int TMO_CYC = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_req,
  input logic             meas_ack,
  input logic             meas_tmo,
  input logic [DAC_W-1:0] dac_code,
  input logic             ramp_en,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [1:0]       err_cause,
  input logic [DIV_W-1:0] div_q
);
  localparam int RW = $clog2(TMO_CYC + 2);

  logic [DAC_W-1:0] code_d;
  logic             en_d;
  logic [DIV_W:0]   hold;
  logic [RW-1:0]    req_cnt;
  logic             code_step;

  assign code_step = ramp_en && en_d && (dac_code != code_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_d <= '0; en_d <= 1'b0; hold <= '0; req_cnt <= '0;
    end else begin
      code_d <= dac_code;
      en_d   <= ramp_en;
      if (!ramp_en)                   hold <= '0;
      else if (!en_d || code_step)    hold <= (DIV_W+1)'(1);
      else                            hold <= hold + 1'b1;
      req_cnt <= meas_req ? req_cnt + 1'b1 : '0;
    end
  end

  assert_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && meas_ack |=> !meas_req);

  assert_req_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req |-> req_cnt < RW'(TMO_CYC));

  assert_tmo_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    meas_tmo |=> err && err_cause == 2'b01);

  assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_step |-> dac_code == code_d + 1'b1);

  assert_hold_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
    code_step |-> hold == {1'b0, div_q} + 1'b1);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> err_cause != 2'b00);

  assert_idle_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ramp_en |-> dac_code == '0);

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramp_en && meas_req) && $onehot0({done, err}));
endmodule

bind rps_two_step_prog rps_two_step_chk #(
  .DAC_W(DAC_W), .DIV_W(DIV_W), .TMO_CYC(TMO_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .meas_req(meas_req), .meas_ack(meas_ack),
  .meas_tmo(meas_tmo), .dac_code(dac_code), .ramp_en(ramp_en), .busy(busy),
  .done(done), .err(err), .err_cause(err_cause), .div_q(div_q)
);

// File: tb/rps_two_step_prog_tb.sv
module rps_two_step_prog_tb_top;
  localparam int LB = 3, DW = 8, VW = 4, TMO = 40, NL = 1 << LB;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, ack_i = 1'b0;
  logic [LB-1:0] level_i = '0;
  logic [NL*DW-1:0] table_i;
  logic [VW-1:0] div_i = '0;
  logic [DW-1:0] ovd_i = '0;
  logic signed [DW+1:0] vt_i = '0;
  logic meas_req, ramp_en, busy, done, err;
  logic [DW-1:0] dac_code;
  logic [1:0] err_cause;

  int checks = 0, errors = 0;
  int exp_code_q[$]; string exp_tag_q[$];
  int exp_cause_q[$]; string out_tag_q[$];
  int vt_q[$];
  bit mute = 1'b0, prev_en = 1'b0;
  int prev_code = 0;

  always #10 clk = ~clk;

  rps_two_step_prog #(.LVL_BITS(LB), .DAC_W(DW), .DIV_W(VW), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start_i), .level(level_i), .lvl_table(table_i),
    .ramp_div(div_i), .ovd_base(ovd_i), .meas_req(meas_req), .meas_ack(ack_i),
    .meas_vt(vt_i), .dac_code(dac_code), .ramp_en(ramp_en), .busy(busy),
    .done(done), .err(err), .err_cause(err_cause)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int tcode(input int k);
    return 40 + 24 * k;
  endfunction

  // Cell model: answer each request after three cycles
  initial begin
    forever begin
      @(negedge clk);
      if (meas_req && !mute) begin
        repeat (3) @(negedge clk);
        ack_i = 1'b1;
        vt_i  = (DW+2)'(vt_q.size() ? vt_q.pop_front() : 0);
        @(negedge clk);
        ack_i = 1'b0;
        check(meas_req == 1'b0, "R2 req after ack", int'(meas_req), 0);
      end
    end
  end

  // Monitor: pop expected ramp codes and outcomes
  always @(negedge clk) begin
    if (rst_n && ramp_en && (!prev_en || int'(dac_code) != prev_code)) begin
      if (exp_code_q.size() == 0) check(1'b0, "R7 unexpected ramp code", int'(dac_code), -1);
      else begin
        automatic int e = exp_code_q.pop_front();
        automatic string t = exp_tag_q.pop_front();
        check(int'(dac_code) == e, t, int'(dac_code), e);
      end
    end
    prev_en = ramp_en; prev_code = int'(dac_code);
    if (rst_n && (done || err)) begin
      if (exp_cause_q.size() == 0) check(1'b0, "R7 unexpected outcome", int'(err_cause), -1);
      else begin
        automatic int c = exp_cause_q.pop_front();
        automatic string t = out_tag_q.pop_front();
        check((done == (c == 0)) && int'(err_cause) == c, t, int'(err_cause), c);
      end
    end
  end

  task automatic push_ramp(input int s, input int e, input string tag);
    for (int c = s; c <= e; c++) begin exp_code_q.push_back(c); exp_tag_q.push_back(tag); end
  endtask

  task automatic run_case(input int lvl, input int ovd, input int dv, input int v0,
                          input int v1, input bit no_ack, input bit poke);
    int tgt, mid, s1, e1, o2, s2, e2, guard;
    tgt = tcode(lvl);
    if (no_ack) begin exp_cause_q.push_back(1); out_tag_q.push_back("R3 timeout"); end
    else if (tgt - v0 < 2) begin exp_cause_q.push_back(3); out_tag_q.push_back("R8 order first"); end
    else begin
      mid = v0 + (tgt - v0) / 2;
      s1 = (v0 + ovd < 0) ? 0 : v0 + ovd;
      e1 = mid + ovd;
      if (e1 > 255 || e1 < 0) begin exp_cause_q.push_back(2); out_tag_q.push_back("R9 range first"); end
      else begin
        push_ramp(s1, e1, "R4 first ramp");
        if (v1 >= tgt) begin exp_cause_q.push_back(3); out_tag_q.push_back("R8 order second"); end
        else begin
          o2 = ovd + mid - v1;
          s2 = (v1 + o2 < 0) ? 0 : v1 + o2;
          e2 = tgt + o2;
          if (e2 > 255 || e2 < 0) begin exp_cause_q.push_back(2); out_tag_q.push_back("R9 range second"); end
          else begin push_ramp(s2, e2, "R6 second ramp"); exp_cause_q.push_back(0); out_tag_q.push_back("R7 done"); end
        end
      end
    end
    vt_q.push_back(v0); vt_q.push_back(v1);
    mute = no_ack;
    @(negedge clk);
    level_i = LB'(lvl); ovd_i = DW'(ovd); div_i = VW'(dv); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy && meas_req, "R1 start accepted", int'({busy, meas_req}), 3);
    if (poke) begin
      repeat (30) @(negedge clk);
      level_i = '0; div_i = '0; ovd_i = 8'd1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!(done || err) && guard < 3000) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(!busy && !meas_req, "R7 idle after outcome", int'({busy, meas_req}), 0);
    check(!ramp_en && dac_code == '0, "R10 code idle", int'(dac_code), 0);
    check(exp_code_q.size() == 0, "R4 R6 codes missing", exp_code_q.size(), 0);
    exp_code_q.delete(); exp_tag_q.delete(); vt_q.delete();
    mute = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < NL; k++) table_i[k*DW +: DW] = DW'(tcode(k));
    repeat (3) @(negedge clk);
    check(!busy && !meas_req && !ramp_en && dac_code == '0 && !done && !err,
          "R10 reset state", int'({busy, meas_req, ramp_en, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(3, 30, 2, 20, 60, 1'b0, 1'b0);     // lagging cell
    run_case(5, 15, 0, -10, 80, 1'b0, 1'b0);    // fast cell, divider 0
    run_case(1, 20, 3, -50, 10, 1'b0, 1'b0);    // clamped start
    run_case(0, 5, 0, 38, 39, 1'b0, 1'b0);      // gap of exactly 2
    run_case(0, 5, 1, 39, 39, 1'b0, 1'b0);      // R8 gap of 1
    run_case(7, 200, 1, 100, 150, 1'b0, 1'b0);  // R9 first end too high
    run_case(2, 10, 1, 10, 90, 1'b0, 1'b0);     // R8 overshoot after ramp
    run_case(7, 40, 0, 0, 20, 1'b0, 1'b0);      // R9 second end too high
    run_case(7, 67, 0, 168, 200, 1'b0, 1'b0);   // end at full scale, then over
    run_case(4, 25, 1, 30, 80, 1'b0, 1'b1);     // R1 start while busy ignored
    run_case(2, 10, 1, 0, 0, 1'b1, 1'b0);       // R3 no ack
    run_case(6, 12, 2, 50, 120, 1'b0, 1'b0);    // recovery after timeout
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule